// File: doc/BRIEF.md
# Programmable Interval Timer with Level and Periodic Interrupt

This block is an 8-bit binary down-counter. Software loads a start value, picks one of four tick rates and sets an enable bit. Each selected tick takes one count off the counter. When the count reaches zero the block sets a sticky event flag and can pull an active-low interrupt line.

The block has two modes. In one-shot (level) mode the interrupt line stays low until software clears the flag. The timer also stops itself at zero. In periodic mode the line drops at each zero event and is released by the next release pulse that matches the tick rate. The start value is then reloaded and the count starts again, so the block works as a repeating interval source.

Tick enables and release pulses come from a divider outside the block. Each is a one-cycle pulse in the system clock domain. The registers sit on a simple nibble-wide bus with a one-cycle write strobe and a combinational read.

Top module: `ivt_timer`

## Requirements
- R1: The source field (setting register, address 4, bits 1:0) selects the tick. 00 selects tick_4k, 01 selects tick_64, 10 selects tick_1s and 11 selects tick_1m. Only the selected tick moves the count.
- R2: The start value is written as a low nibble at address 0 and a high nibble at address 1. Each write also loads that value into the counter. The live count reads back at address 2 (low nibble) and address 3 (high nibble). The stored start value stays unchanged while the timer counts.
- R3: The setting register at address 4 holds the run bit (bit 3), the mode bit (bit 2: 0 = level, 1 = periodic) and the source field. Writing the run bit as 0 freezes the count. A start followed by a stop with no selected tick in between leaves the count unchanged.
- R4: The flag (control register, address 5, bit 1) is set when the count steps from 1 to 0. It stays set until a write of 0 to that bit. A write of 1 to the flag has no effect.
- R5: In level mode, irq_n is low whenever the flag and the interrupt-enable bit (address 5, bit 0) are both 1. At zero the run bit clears itself and the count stays at 0.
- R6: If the timer was started while the flag was already 1, reaching zero in level mode leaves the run bit set.
- R7: In periodic mode, irq_n goes low at each zero event. It is released by rel_short when the source is 00, and by rel_long for any other source. On that release the start value is reloaded and counting resumes. The flag stays at 1.
- R8: With the run bit set and a start value of zero, no zero event occurs and the flag stays 0.
- R9: With the interrupt-enable bit at 0, irq_n stays high even while the flag is 1.
- R10: After reset, all registers read 0 and irq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_4k | input | 1 | 4096 Hz tick enable pulse |
| tick_64 | input | 1 | 64 Hz tick enable pulse |
| tick_1s | input | 1 | 1 Hz tick enable pulse |
| tick_1m | input | 1 | One-per-minute tick enable pulse |
| rel_short | input | 1 | Short release-interval pulse (used with the 4096 Hz source) |
| rel_long | input | 1 | Long release-interval pulse (used with the other sources) |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 4 | Write data nibble |
| reg_rdata | output | 4 | Read data nibble for reg_addr |
| irq_n | output | 1 | Active-low interrupt (1 means released) |

## Verification
The bench targets these corner cases, and each one shows a specific wrong design:
- A timer restarted while its flag is still set must keep running past zero. A design that always clears its run bit would read back a stopped timer.
- A write of 1 to the flag must do nothing. A design that honours it would raise an interrupt with no event behind it.
- In periodic mode the bench sends the wrong release pulse first. A design that mixes up the two release intervals would let go of irq_n too early, or never reload.
- The bench runs periodic mode from a zero start value, which must produce no event. It also starts and stops the timer with no tick in between. In both cases a design that counts or fires spuriously shows a moved count or a set flag.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [1:0] {
    SRC_4K  = 2'b00,
    SRC_64  = 2'b01,
    SRC_1S  = 2'b10,
    SRC_1M  = 2'b11
  } ivt_src_e;

  typedef enum logic {
    MODE_LEVEL    = 1'b0,
    MODE_PERIODIC = 1'b1
  } ivt_mode_e;

  localparam int unsigned NUM_SRC = 4;

endpackage

// File: rtl/ivt_src_mux.sv
module ivt_src_mux
  import ivt_pkg::*;
(
  input  logic [NUM_SRC-1:0] ticks,
  input  ivt_src_e           sel,
  input  logic               rel_short,
  input  logic               rel_long,
  output logic               tick,
  output logic               rel
);

  logic [NUM_SRC-1:0] hit;

  // one-hot gating of each tick source against the select field
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign hit[s] = ticks[s] && (sel == ivt_src_e'(s));
  end

  assign tick = |hit;
  // the fastest source owns the short release, all others the long one
  assign rel  = (sel == SRC_4K) ? rel_short : rel_long;

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
  import ivt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  ivt_mode_e        mode,
  input  logic             tick,
  input  logic             rel,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             pend,
  output logic             zero_evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;

  always_comb begin
    cnt_d    = cnt_q;
    pend_d   = pend_q;
    zero_evt = 1'b0;
    if (!en) begin
      pend_d = 1'b0;
    end else if (pend_q) begin
      if (rel) begin
        pend_d = 1'b0;
        cnt_d  = load_val;
      end
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - ONE;
      if (cnt_q == ONE) begin
        zero_evt = 1'b1;
        if (mode == MODE_PERIODIC) pend_d = 1'b1;
      end
    end
    if (load) cnt_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign count = cnt_q;
  assign pend  = pend_q;

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && en && !rel) |=> pend_q);

  // R2
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(pend_q && rel && en)) |=> (cnt_q <= $past(cnt_q)));

  // R8
  evt_from_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(cnt_q) == ONE));

endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              zero_evt,
  output logic [3:0]        rdata,
  output logic [CNT_W-1:0]  preset_nxt,
  output logic              load,
  output logic              en,
  output ivt_mode_e         mode,
  output ivt_src_e          sel,
  output logic              ie,
  output logic              flag
);

  localparam int unsigned NIB   = CNT_W / 4;
  localparam int unsigned SET_A = 2 * NIB;
  localparam int unsigned CTL_A = 2 * NIB + 1;

  logic [CNT_W-1:0] preset_q;
  logic [NIB-1:0]   nib_we;
  logic             set_we, ctl_we;

  logic      en_q, en_d;
  logic      keep_q, keep_d;
  logic      flag_q, flag_d;
  logic      ie_q, ie_d;
  ivt_mode_e mode_q, mode_d;
  ivt_src_e  sel_q, sel_d;

  for (genvar i = 0; i < NIB; i++) begin : g_nib
    assign nib_we[i] = wr && (addr == ADDR_W'(i));
    assign preset_nxt[4*i +: 4] = nib_we[i] ? wdata : preset_q[4*i +: 4];
  end

  assign load   = |nib_we;
  assign set_we = wr && (addr == ADDR_W'(SET_A));
  assign ctl_we = wr && (addr == ADDR_W'(CTL_A));

  always_comb begin
    en_d   = en_q;
    keep_d = keep_q;
    flag_d = flag_q;
    ie_d   = ie_q;
    mode_d = mode_q;
    sel_d  = sel_q;
    if (zero_evt) begin
      flag_d = 1'b1;
      if ((mode_q == MODE_LEVEL) && !keep_q) en_d = 1'b0;
    end
    if (set_we) begin
      en_d   = wdata[3];
      mode_d = ivt_mode_e'(wdata[2]);
      sel_d  = ivt_src_e'(wdata[1:0]);
      if (wdata[3] && !en_q) keep_d = flag_q;
    end
    if (ctl_we) begin
      ie_d = wdata[0];
      if (!wdata[1]) flag_d = zero_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '0;
      en_q     <= 1'b0;
      keep_q   <= 1'b0;
      flag_q   <= 1'b0;
      ie_q     <= 1'b0;
      mode_q   <= MODE_LEVEL;
      sel_q    <= SRC_4K;
    end else begin
      if (load) preset_q <= preset_nxt;
      en_q   <= en_d;
      keep_q <= keep_d;
      flag_q <= flag_d;
      ie_q   <= ie_d;
      mode_q <= mode_d;
      sel_q  <= sel_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NIB; i++) begin
      if (addr == ADDR_W'(i))       rdata = preset_q[4*i +: 4];
      if (addr == ADDR_W'(NIB + i)) rdata = count[4*i +: 4];
    end
    if (addr == ADDR_W'(SET_A)) rdata = {en_q, mode_q, sel_q};
    if (addr == ADDR_W'(CTL_A)) rdata = {2'b00, flag_q, ie_q};
  end

  assign en   = en_q;
  assign mode = mode_q;
  assign sel  = sel_q;
  assign ie   = ie_q;
  assign flag = flag_q;

  // R4
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(zero_evt));

  // R5
  level_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && (mode_q == MODE_LEVEL) && !keep_q && !set_we) |=> !en_q);

  // R6
  keep_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && keep_q && !set_we) |=> en_q);

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_4k,
  input  logic              tick_64,
  input  logic              tick_1s,
  input  logic              tick_1m,
  input  logic              rel_short,
  input  logic              rel_long,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [3:0]        reg_wdata,
  output logic [3:0]        reg_rdata,
  output logic              irq_n
);

  logic [CNT_W-1:0] count, preset_nxt;
  logic             load, en, ie, flag, pend, zero_evt, tick, rel;
  ivt_mode_e        mode;
  ivt_src_e         sel;

  ivt_src_mux u_mux (
    .ticks     ({tick_1m, tick_1s, tick_64, tick_4k}),
    .sel       (sel),
    .rel_short (rel_short),
    .rel_long  (rel_long),
    .tick      (tick),
    .rel       (rel)
  );

  ivt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .count      (count),
    .zero_evt   (zero_evt),
    .rdata      (reg_rdata),
    .preset_nxt (preset_nxt),
    .load       (load),
    .en         (en),
    .mode       (mode),
    .sel        (sel),
    .ie         (ie),
    .flag       (flag)
  );

  ivt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .mode     (mode),
    .tick     (tick),
    .rel      (rel),
    .load     (load),
    .load_val (preset_nxt),
    .count    (count),
    .pend     (pend),
    .zero_evt (zero_evt)
  );

  assign irq_n = !(ie && ((mode == MODE_PERIODIC) ? pend : flag));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n) |-> (flag || pend));

endmodule

// File: tb/ivt_timer_test.sv
`timescale 1ns/1ps
module ivt_timer_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_4k, tick_64, tick_1s, tick_1m, rel_short, rel_long;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [3:0] reg_wdata;
  logic [3:0] reg_rdata;
  logic       irq_n;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  ivt_timer uut (
    .clk(clk), .rst_n(rst_n),
    .tick_4k(tick_4k), .tick_64(tick_64), .tick_1s(tick_1s), .tick_1m(tick_1m),
    .rel_short(rel_short), .rel_long(rel_long),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [3:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd_cnt(output logic [7:0] c);
    logic [3:0] lo, hi;
    rd(3'd2, lo); rd(3'd3, hi); c = {hi, lo};
  endtask

  // 0:4k 1:64 2:1s 3:1m 4:rel_short 5:rel_long
  task automatic pulse(input int k);
    @(negedge clk);
    case (k)
      0: tick_4k = 1'b1;
      1: tick_64 = 1'b1;
      2: tick_1s = 1'b1;
      3: tick_1m = 1'b1;
      4: rel_short = 1'b1;
      default: rel_long = 1'b1;
    endcase
    @(negedge clk);
    tick_4k = 0; tick_64 = 0; tick_1s = 0; tick_1m = 0; rel_short = 0; rel_long = 0;
  endtask

  task automatic t_reset;
    logic [3:0] d; logic [7:0] c;
    rd_cnt(c); chk("R10 count", c, 8'h00);
    rd(3'd4, d); chk("R10 setting", {4'h0, d}, 8'h00);
    rd(3'd5, d); chk("R10 control", {4'h0, d}, 8'h00);
    chk("R10 irq_n", {7'h0, irq_n}, 8'h01);
  endtask

  task automatic t_preset;
    logic [3:0] d; logic [7:0] c;
    wr(3'd0, 4'hA); wr(3'd1, 4'h5);
    rd_cnt(c); chk("R2 count load", c, 8'h5A);
    rd(3'd0, d); chk("R2 preset lo", {4'h0, d}, 8'h0A);
    rd(3'd1, d); chk("R2 preset hi", {4'h0, d}, 8'h05);
  endtask

  task automatic t_level;
    logic [3:0] d; logic [7:0] c;
    wr(3'd5, 4'b0001); wr(3'd0, 4'h3); wr(3'd1, 4'h0);
    wr(3'd4, 4'b1010);
    pulse(0); pulse(1); pulse(3);
    rd_cnt(c); chk("R1 unselected ticks", c, 8'h03);
    pulse(2); pulse(2);
    rd_cnt(c); chk("R1 1s decrement", c, 8'h01);
    chk("R5 irq before zero", {7'h0, irq_n}, 8'h01);
    pulse(2);
    chk("R5 irq low", {7'h0, irq_n}, 8'h00);
    rd(3'd5, d); chk("R4 flag set", {4'h0, d}, 8'h03);
    rd(3'd4, d); chk("R5 run cleared", {4'h0, d}, 8'h02);
    pulse(2);
    rd_cnt(c); chk("R5 count held", c, 8'h00);
    rd(3'd0, d); chk("R2 preset kept", {4'h0, d}, 8'h03);
  endtask

  task automatic t_flag;
    logic [3:0] d;
    wr(3'd5, 4'b0001);
    rd(3'd5, d); chk("R4 flag cleared", {4'h0, d}, 8'h01);
    chk("R4 irq released", {7'h0, irq_n}, 8'h01);
    wr(3'd5, 4'b0011);
    rd(3'd5, d); chk("R4 write one ignored", {4'h0, d}, 8'h01);
    chk("R4 irq stays high", {7'h0, irq_n}, 8'h01);
  endtask

  task automatic t_ie;
    logic [3:0] d;
    wr(3'd0, 4'h1); wr(3'd4, 4'b1000);
    pulse(0);
    chk("R5 irq on 4k", {7'h0, irq_n}, 8'h00);
    wr(3'd5, 4'b0010);
    chk("R9 ie off releases", {7'h0, irq_n}, 8'h01);
    rd(3'd5, d); chk("R9 flag still set", {4'h0, d}, 8'h02);
    wr(3'd5, 4'b0011);
    chk("R9 ie on asserts", {7'h0, irq_n}, 8'h00);
  endtask

  task automatic t_keep;
    logic [3:0] d; logic [7:0] c;
    wr(3'd0, 4'h2); wr(3'd4, 4'b1000);
    pulse(0); pulse(0);
    rd_cnt(c); chk("R6 count zero", c, 8'h00);
    rd(3'd4, d); chk("R6 run kept", {4'h0, d}, 8'h08);
    wr(3'd4, 4'b0000); wr(3'd5, 4'b0001);
  endtask

  task automatic t_per_short;
    logic [3:0] d; logic [7:0] c;
    wr(3'd0, 4'h2); wr(3'd4, 4'b1100);
    pulse(0); pulse(0);
    chk("R7 irq at zero", {7'h0, irq_n}, 8'h00);
    pulse(5);
    chk("R7 wrong release ignored", {7'h0, irq_n}, 8'h00);
    pulse(4);
    chk("R7 short release", {7'h0, irq_n}, 8'h01);
    rd_cnt(c); chk("R7 reloaded", c, 8'h02);
    rd(3'd5, d); chk("R7 flag held", {4'h0, d}, 8'h03);
    pulse(0); pulse(0);
    chk("R7 second period", {7'h0, irq_n}, 8'h00);
    pulse(4);
    wr(3'd4, 4'b0000); wr(3'd5, 4'b0001);
  endtask

  task automatic t_per_long;
    logic [7:0] c;
    wr(3'd0, 4'h1); wr(3'd4, 4'b1101);
    pulse(1);
    chk("R7 irq on 64", {7'h0, irq_n}, 8'h00);
    pulse(4);
    chk("R7 short ignored for 64", {7'h0, irq_n}, 8'h00);
    pulse(5);
    chk("R7 long release", {7'h0, irq_n}, 8'h01);
    rd_cnt(c); chk("R7 reload 64", c, 8'h01);
    wr(3'd4, 4'b0000); wr(3'd5, 4'b0001);
  endtask

  task automatic t_zero;
    logic [3:0] d;
    wr(3'd0, 4'h0); wr(3'd1, 4'h0); wr(3'd4, 4'b1100);
    pulse(0); pulse(0); pulse(0);
    chk("R8 no irq", {7'h0, irq_n}, 8'h01);
    rd(3'd5, d); chk("R8 no flag", {4'h0, d}, 8'h01);
    wr(3'd4, 4'b0000);
  endtask

  task automatic t_startstop;
    logic [7:0] c;
    wr(3'd0, 4'h5);
    wr(3'd4, 4'b1000); wr(3'd4, 4'b0000);
    pulse(0);
    rd_cnt(c); chk("R3 no tick no count", c, 8'h05);
    wr(3'd4, 4'b1000); pulse(0);
    rd_cnt(c); chk("R3 running count", c, 8'h04);
    wr(3'd4, 4'b0000); pulse(0);
    rd_cnt(c); chk("R3 stopped frozen", c, 8'h04);
  endtask

  task automatic t_minute;
    logic [7:0] c;
    wr(3'd0, 4'h2); wr(3'd4, 4'b1011);
    pulse(2); pulse(0);
    rd_cnt(c); chk("R1 minute ignores others", c, 8'h02);
    pulse(3);
    rd_cnt(c); chk("R1 minute tick", c, 8'h01);
    wr(3'd4, 4'b0000);
  endtask

  initial begin
    #(5.0 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tick_4k = 0; tick_64 = 0; tick_1s = 0; tick_1m = 0; rel_short = 0; rel_long = 0;
    reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_preset();
    t_level();
    t_flag();
    t_ie();
    t_keep();
    t_per_short();
    t_per_long();
    t_zero();
    t_startstop();
    t_minute();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule